// File: doc/BRIEF.md
# Out-of-Order Response Reorder Buffer

This block sits between a requester and a target that may keep several requests open at once and may return their answers in any order. The requester issues requests through a valid/ready port. Each accepted request is forwarded to the target together with a transaction tag, and the tags are taken from a wrapping issue pointer. The target answers with the same tag, and the returned data is stored in the buffer slot that the tag selects.

The consumer side receives the data strictly in the order in which the requests were accepted. An in-flight counter limits open requests to `MAX_OUT`. A tag is reused only after its data has been handed to the consumer. A response whose tag does not belong to an open, still-empty slot raises a one-cycle error flag and changes nothing.

Top module: `ooo_reorder_buf`

## Requirements
- R1: After reset `out_valid` and `rsp_err` are 0, `dn_id` is 0 and `up_ready` equals `dn_ready`.
- R2: While fewer than `MAX_OUT` requests are open, `dn_valid` follows `up_valid`, `dn_payload` equals `up_payload`, and `up_ready` equals `dn_ready`. A request is accepted on a clock edge where `up_valid` and `up_ready` are both 1.
- R3: Accepted requests receive tags 0, 1, ..., `MAX_OUT`-1 on `dn_id` and then wrap to 0. The tag advances only on acceptance.
- R4: With `MAX_OUT` requests open, `up_ready` and `dn_valid` are 0 whatever `up_valid` is.
- R5: A response with `rsp_valid`=1 stores `rsp_data` in the slot named by `rsp_id`. Stored data leaves on `out_data` in acceptance order, whatever order the responses arrived in.
- R6: `out_valid` is 1 only when the oldest open request has its response stored. A stored response for a younger request keeps `out_valid` at 0.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` holds its value on the next cycle.
- R8: A delivery (`out_valid` and `out_ready` both 1) closes the oldest request. After a delivery from the full state, `up_ready` returns to `dn_ready` on the next cycle.
- R9: A response whose tag is not open, or whose slot already holds data, drives `rsp_err` to 1 in that same cycle and leaves the stored data and `out_valid` unchanged.
- R10: An acceptance and a delivery on the same edge leave the count of open requests unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Requester offers a request |
| up_ready | output | 1 | Request can be accepted this cycle |
| up_payload | input | PAY_W | Request payload |
| dn_valid | output | 1 | Request forwarded to target |
| dn_ready | input | 1 | Target can take a request |
| dn_payload | output | PAY_W | Forwarded payload |
| dn_id | output | ID_W | Tag of the forwarded request |
| rsp_valid | input | 1 | Target returns a response |
| rsp_id | input | ID_W | Tag of the response |
| rsp_data | input | DATA_W | Response data |
| rsp_err | output | 1 | Response tag not open or slot already filled |
| out_valid | output | 1 | Oldest request's data is available |
| out_ready | input | 1 | Consumer takes the data |
| out_data | output | DATA_W | Data of the oldest open request |

## Verification
A corrupted head pointer or filled flag shows at `out_data` on the very next delivery, as data from the wrong tag or data offered too early. The bench therefore gives every response distinct data and returns responses in scrambled orders. A drifting in-flight count shows within at most `MAX_OUT` acceptances, as `up_ready` dropping too early or staying high past the limit. A wrong tag pointer shows as soon as the next request appears on `dn_id`. An ignored response that still writes its slot shows on the next delivery of that slot, where the stored data would differ from the first response.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // next pointer value with wrap at n entries
  function automatic int unsigned ptr_next(int unsigned p, int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  // open-request count after one edge
  function automatic int unsigned cnt_next(int unsigned c, logic inc, logic dec);
    int unsigned r;
    r = c;
    if (inc && !dec) r = c + 1;
    if (dec && !inc) r = c - 1;
    return r;
  endfunction
endpackage

// File: rtl/rob_issue_ctl.sv
module rob_issue_ctl #(
  parameter int MAX_OUT = 4,
  localparam int ID_W   = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1,
  localparam int CNT_W  = $clog2(MAX_OUT) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            up_valid,
  input  logic            dn_ready,
  input  logic            dlv,
  output logic            up_ready,
  output logic            dn_valid,
  output logic [ID_W-1:0] issue_id,
  output logic            accept,
  output logic            full
);
  import rob_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [ID_W-1:0]  ptr_q;

  assign full     = (int'(cnt_q) == MAX_OUT);
  assign up_ready = dn_ready && !full;
  assign dn_valid = up_valid && !full;
  assign accept   = up_valid && up_ready;
  assign issue_id = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ptr_q <= '0;
    end else begin
      cnt_q <= CNT_W'(cnt_next(int'(cnt_q), accept, dlv));
      if (accept) ptr_q <= ID_W'(ptr_next(int'(ptr_q), MAX_OUT));
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= MAX_OUT); // R4
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !accept && !dn_valid); // R4
  AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dlv) |=> $stable(cnt_q)); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dlv |-> cnt_q != '0); // R8
endmodule

// File: rtl/rob_slot_array.sv
module rob_slot_array #(
  parameter int MAX_OUT = 4,
  parameter int DATA_W  = 16,
  localparam int ID_W   = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ID_W-1:0]   issue_id,
  input  logic              rsp_valid,
  input  logic [ID_W-1:0]   rsp_id,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              dlv,
  input  logic [ID_W-1:0]   head_id,
  output logic              head_filled,
  output logic [DATA_W-1:0] head_data,
  output logic              rsp_wr,
  output logic              rsp_err
);
  logic [MAX_OUT-1:0] pend_q;
  logic [MAX_OUT-1:0] fill_q;
  logic [DATA_W-1:0]  data_q [MAX_OUT];
  logic               slot_open;

  always_comb begin
    slot_open   = 1'b0;
    head_filled = 1'b0;
    head_data   = '0;
    for (int i = 0; i < MAX_OUT; i++) begin
      if (rsp_id == ID_W'(i)) slot_open = pend_q[i] && !fill_q[i];
      if (head_id == ID_W'(i)) begin
        head_filled = fill_q[i];
        head_data   = data_q[i];
      end
    end
  end

  assign rsp_wr  = rsp_valid && slot_open;
  assign rsp_err = rsp_valid && !slot_open;

  for (genvar g = 0; g < MAX_OUT; g++) begin : g_slot
    logic issue_hit, fill_hit, free_hit;
    assign issue_hit = accept && (issue_id == ID_W'(g));
    assign fill_hit  = rsp_wr && (rsp_id == ID_W'(g));
    assign free_hit  = dlv && (head_id == ID_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
        fill_q[g] <= 1'b0;
        data_q[g] <= '0;
      end else begin
        if (issue_hit)     pend_q[g] <= 1'b1;
        else if (free_hit) pend_q[g] <= 1'b0;
        if (fill_hit)      fill_q[g] <= 1'b1;
        else if (free_hit) fill_q[g] <= 1'b0;
        if (fill_hit)      data_q[g] <= rsp_data;
      end
    end

    AST_FILL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q[g] |-> pend_q[g]); // R9
    AST_ERR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_err && !fill_hit) |=> $stable(data_q[g])); // R9
  end
endmodule

// File: rtl/rob_release.sv
module rob_release #(
  parameter int MAX_OUT = 4,
  localparam int ID_W   = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            head_filled,
  input  logic            out_ready,
  output logic            out_valid,
  output logic            dlv,
  output logic [ID_W-1:0] head_id
);
  import rob_pkg::*;

  logic [ID_W-1:0] head_q;

  assign out_valid = head_filled;
  assign dlv       = out_valid && out_ready;
  assign head_id   = head_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   head_q <= '0;
    else if (dlv) head_q <= ID_W'(ptr_next(int'(head_q), MAX_OUT));
  end

  AST_HEAD_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    dlv |=> head_q != $past(head_q)); // R5
  AST_HEAD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !dlv |=> $stable(head_q)); // R6
endmodule

// File: rtl/ooo_reorder_buf.sv
module ooo_reorder_buf #(
  parameter int MAX_OUT = 4,
  parameter int PAY_W   = 16,
  parameter int DATA_W  = 16,
  localparam int ID_W   = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [PAY_W-1:0]  up_payload,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [PAY_W-1:0]  dn_payload,
  output logic [ID_W-1:0]   dn_id,
  input  logic              rsp_valid,
  input  logic [ID_W-1:0]   rsp_id,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  // internal events, named for the assertions
  logic            accept;
  logic            full;
  logic            dlv;
  logic            rsp_wr;
  logic            head_filled;
  logic [ID_W-1:0] head_id;

  assign dn_payload = up_payload;

  rob_issue_ctl #(.MAX_OUT(MAX_OUT)) u_issue (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .dn_ready(dn_ready),
    .dlv(dlv), .up_ready(up_ready), .dn_valid(dn_valid), .issue_id(dn_id),
    .accept(accept), .full(full)
  );

  rob_slot_array #(.MAX_OUT(MAX_OUT), .DATA_W(DATA_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .accept(accept), .issue_id(dn_id),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data),
    .dlv(dlv), .head_id(head_id), .head_filled(head_filled),
    .head_data(out_data), .rsp_wr(rsp_wr), .rsp_err(rsp_err)
  );

  rob_release #(.MAX_OUT(MAX_OUT)) u_rel (
    .clk(clk), .rst_n(rst_n), .head_filled(head_filled),
    .out_ready(out_ready), .out_valid(out_valid), .dlv(dlv),
    .head_id(head_id)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data)); // R7
  AST_WR_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_wr && rsp_err)); // R9
  AST_FULL_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !up_ready); // R4
endmodule

// File: tb/sim_ooo_reorder_buf.sv
module sim_ooo_reorder_buf;
  localparam int N  = 4;
  localparam int PW = 16;
  localparam int DW = 16;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic up_valid, up_ready, dn_valid, dn_ready;
  logic [PW-1:0] up_payload, dn_payload;
  logic [IW-1:0] dn_id, rsp_id;
  logic rsp_valid, rsp_err, out_valid, out_ready;
  logic [DW-1:0] rsp_data, out_data;

  int n_chk = 0;
  int n_bad = 0;
  int exp_id = 0;

  always #10 clk = ~clk;

  ooo_reorder_buf #(.MAX_OUT(N), .PAY_W(PW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_payload(up_payload), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_payload(dn_payload), .dn_id(dn_id), .rsp_valid(rsp_valid),
    .rsp_id(rsp_id), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    up_valid = 0; rsp_valid = 0; out_ready = 0; dn_ready = 1;
  endtask

  // one accepted request; checks forwarding and tag (R2, R3)
  task automatic issue(logic [PW-1:0] pay);
    @(negedge clk);
    up_valid = 1; up_payload = pay;
    #2;
    chk("R2 dn_valid", dn_valid, 1);
    chk("R2 dn_payload", dn_payload, pay);
    chk("R2 up_ready", up_ready, 1);
    chk("R3 dn_id", dn_id, exp_id);
    exp_id = (exp_id + 1) % N;
    idle();
  endtask

  task automatic respond(int id, logic [DW-1:0] d, logic exp_err, logic exp_ov);
    @(negedge clk);
    rsp_valid = 1; rsp_id = IW'(id); rsp_data = d;
    #2;
    chk("R9 rsp_err", rsp_err, exp_err);
    idle();
    #2;
    chk("R6 out_valid after response", out_valid, exp_ov);
  endtask

  task automatic pop(logic [DW-1:0] d);
    @(negedge clk);
    out_ready = 1;
    #2;
    chk("R6 out_valid", out_valid, 1);
    chk("R5 out_data order", out_data, d);
    idle();
  endtask

  task automatic t_reset();
    rst_n = 0; up_valid = 0; rsp_valid = 0; out_ready = 0; dn_ready = 1;
    up_payload = 0; rsp_id = 0; rsp_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #2;
    chk("R1 out_valid", out_valid, 0);
    chk("R1 rsp_err", rsp_err, 0);
    chk("R1 dn_id", dn_id, 0);
    chk("R1 up_ready", up_ready, 1);
    exp_id = 0;
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    dn_ready = 0; up_valid = 1; up_payload = 16'h1234;
    #2;
    chk("R2 up_ready low", up_ready, 0);
    chk("R2 dn_valid high", dn_valid, 1);
    idle();
    #2;
    chk("R3 tag held", dn_id, exp_id);
  endtask

  task automatic t_scrambled();
    for (int i = 0; i < N; i++) issue(PW'(16'h100 + i));
    @(negedge clk);
    up_valid = 1;
    #2;
    chk("R4 up_ready full", up_ready, 0);
    chk("R4 dn_valid full", dn_valid, 0);
    idle();
    respond(3, 16'hD3, 0, 0);
    respond(1, 16'hD1, 0, 0);
    respond(0, 16'hD0, 0, 1);
    // stall: output held (R7)
    repeat (2) begin
      @(negedge clk); #2;
      chk("R7 hold valid", out_valid, 1);
      chk("R7 hold data", out_data, 16'hD0);
    end
    pop(16'hD0);
    #2;
    chk("R8 up_ready after free", up_ready, 1);
    pop(16'hD1);
    #2;
    chk("R6 head empty", out_valid, 0);
    respond(2, 16'hD2, 0, 1);
    pop(16'hD2);
    pop(16'hD3);
    #2;
    chk("R6 drained", out_valid, 0);
  endtask

  task automatic t_errors();
    respond(1, 16'hEE, 1, 0);          // R9 tag not open
    issue(16'h200);                    // tag 0
    respond(0, 16'hA0, 0, 1);
    respond(0, 16'hB0, 1, 1);          // R9 slot already filled
    pop(16'hA0);
    #2;
    chk("R9 no spurious output", out_valid, 0);
  endtask

  task automatic t_concurrent();
    issue(16'h300);                    // tag 1
    respond(1, 16'hC1, 0, 1);
    @(negedge clk);
    up_valid = 1; up_payload = 16'h301; out_ready = 1;
    #2;
    chk("R10 accept ok", up_ready, 1);
    chk("R10 tag", dn_id, exp_id);
    chk("R10 out_data", out_data, 16'hC1);
    exp_id = (exp_id + 1) % N;
    idle();
    for (int i = 0; i < N - 1; i++) issue(PW'(16'h310 + i));
    @(negedge clk);
    up_valid = 1;
    #2;
    chk("R10 full after N", up_ready, 0);
    idle();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_backpressure();
        t_scrambled();
        t_errors();
        t_concurrent();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule